// File: doc/BRIEF.md
# Serial ADC Sample Readout Controller

This block sits on the host side of a three-wire serial sampling converter: a convert strobe, a serial clock and one serial data line. It starts each conversion by raising the convert strobe and holds it for a fixed number of system clock cycles, long enough for the converter's internal conversion, while the serial clock stays low. It then drops the strobe. That falling edge makes the converter present its most significant result bit. The controller samples that bit, then makes eleven serial clock pulses and samples one more bit after each falling edge. The twelve bits form one straight binary word.

Each finished word is offered on a valid/ready output. The word and `o_valid` stay unchanged until the consumer accepts them in a cycle where both `o_valid` and `o_ready` are high. While an unaccepted word is held, no new conversion starts, so no word is ever overwritten or dropped. With `o_ready` held high, `o_valid` is a one-cycle pulse. The `run` input allows conversions to start. Parameters set the conversion hold time, the serial clock phase lengths, the settle time before the first sample and the start-to-start period. At 200 MHz the defaults give 1400 ns conversion, a 20 MHz serial clock and a 2000 ns sample period.

Top module: `adc_reader`

## Requirements
- R1: While `rst_n` is low, `adc_conv`, `adc_sck` and `o_valid` are all low.
- R2: Each conversion holds `adc_conv` high for exactly CONV_CYC cycles (default 280 cycles, 1400 ns).
- R3: `adc_sck` is low during every cycle in which `adc_conv` is high.
- R4: Each conversion produces exactly WIDTH-1 (11) falling edges on `adc_sck`. Each high phase lasts SCK_HI cycles and each low phase lasts SCK_LO cycles (default 5 and 5, i.e. 25 ns each and 20 MHz).
- R5: The first bit is sampled from `adc_sdo` LEAD_CYC cycles after `adc_conv` falls, which is before the first `adc_sck` rise. Each later bit is sampled SCK_LO cycles after an `adc_sck` fall. The first bit sampled becomes `o_data[11]` and the last becomes `o_data[0]`.
- R6: `o_valid` rises CONV_CYC + LEAD_CYC + 11*(SCK_HI+SCK_LO) + 1 cycles after `adc_conv` rises (default 394 cycles, 1970 ns).
- R7: With `run` and `o_ready` held high, `adc_conv` rises every PERIOD cycles (default 400 cycles, 2000 ns).
- R8: While `o_valid` is high and `o_ready` is low, `o_valid` and `o_data` hold their values and no conversion starts. A word is consumed in a cycle with both high, and the next conversion may start in that same cycle.
- R9: A conversion starts only in a cycle where `run` is high. Lowering `run` lets a conversion already in progress finish and deliver its word.
- R10: `adc_conv` rises no sooner than 3 cycles (15 ns) after the last `adc_sck` fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Allows new conversions to start |
| adc_conv | output | 1 | Convert strobe to the converter |
| adc_sck | output | 1 | Serial clock to the converter, idles low |
| adc_sdo | input | 1 | Serial data from the converter |
| o_valid | output | 1 | Result word available |
| o_ready | input | 1 | Consumer accepts the result word |
| o_data | output | WIDTH (12) | Result word, straight binary, first bit in the MSB |

## Verification
A phase counter that is wrong shows at the pins within one conversion. The strobe width would be wrong at the falling edge, or the clock phase lengths would be wrong at the next clock edge. The number of serial clock falls would be off by the time the word is delivered. A bit index that slips corrupts `o_data` on the first word delivered, because each test word has distinct bits at both ends and in the middle. A broken output-slot or start gate shows up under back-pressure: a held word changes, or a strobe rise appears that the bench can see within one period. A wrong period counter moves the next strobe rise and is caught on the next conversion.

// File: rtl/adc_reader_pkg.sv
`timescale 1ns/1ps
package adc_reader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } rd_state_e;

endpackage

// File: rtl/adc_reader_seq.sv
`timescale 1ns/1ps
module adc_reader_seq
  import adc_reader_pkg::*;
#(
  parameter int WIDTH    = 12,
  parameter int CONV_CYC = 280,
  parameter int LEAD_CYC = 3,
  parameter int SCK_HI   = 5,
  parameter int SCK_LO   = 5,
  parameter int PERIOD   = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok,
  output logic conv,
  output logic sck,
  output logic cap,
  output logic cap_last
);

  localparam int PH_W  = $clog2(PERIOD + 1);
  localparam int BIT_W = $clog2(WIDTH + 1);
  localparam logic [PH_W-1:0]  CONV_END = PH_W'(CONV_CYC - 1);
  localparam logic [PH_W-1:0]  LEAD_END = PH_W'(LEAD_CYC - 1);
  localparam logic [PH_W-1:0]  HI_END   = PH_W'(SCK_HI - 1);
  localparam logic [PH_W-1:0]  LO_END   = PH_W'(SCK_LO - 1);
  localparam logic [PH_W-1:0]  PER_END  = PH_W'(PERIOD - 2);
  localparam logic [PH_W-1:0]  PER_MAX  = {PH_W{1'b1}};
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WIDTH - 1);

  rd_state_e        state;
  logic [PH_W-1:0]  ph;
  logic [PH_W-1:0]  per;
  logic [BIT_W-1:0] nbit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ph    <= '0;
      per   <= '0;
      nbit  <= '0;
      conv  <= 1'b0;
      sck   <= 1'b0;
    end else begin
      if (state != ST_IDLE && per != PER_MAX) per <= per + 1'b1;
      case (state)
        ST_IDLE: if (start_ok) begin
          state <= ST_CONV;
          conv  <= 1'b1;
          ph    <= '0;
          per   <= '0;
        end
        ST_CONV: if (ph == CONV_END) begin
          state <= ST_LEAD;
          conv  <= 1'b0;
          ph    <= '0;
        end else ph <= ph + 1'b1;
        ST_LEAD: if (ph == LEAD_END) begin
          state <= ST_HIGH;
          sck   <= 1'b1;
          ph    <= '0;
          nbit  <= BIT_W'(1);
        end else ph <= ph + 1'b1;
        ST_HIGH: if (ph == HI_END) begin
          state <= ST_LOW;
          sck   <= 1'b0;
          ph    <= '0;
        end else ph <= ph + 1'b1;
        ST_LOW: if (ph == LO_END) begin
          ph <= '0;
          if (nbit == BIT_LAST) state <= ST_GAP;
          else begin
            state <= ST_HIGH;
            sck   <= 1'b1;
            nbit  <= nbit + 1'b1;
          end
        end else ph <= ph + 1'b1;
        ST_GAP: if (per >= PER_END) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cap      = (state == ST_LEAD && ph == LEAD_END) ||
               (state == ST_LOW  && ph == LO_END);
    cap_last = (state == ST_LOW && ph == LO_END && nbit == BIT_LAST);
  end

endmodule

// File: rtl/adc_reader_shift.sv
`timescale 1ns/1ps
module adc_reader_shift #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdo,
  input  logic             cap,
  input  logic             cap_last,
  output logic [WIDTH-1:0] word,
  output logic             done
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
      done <= 1'b0;
    end else begin
      done <= cap_last;
      if (cap) word <= {word[WIDTH-2:0], sdo};
    end
  end

endmodule

// File: rtl/adc_reader_slot.sv
`timescale 1ns/1ps
module adc_reader_slot #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             ready,
  output logic             valid,
  output logic [WIDTH-1:0] data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_reader.sv
`timescale 1ns/1ps
module adc_reader #(
  parameter int WIDTH    = 12,
  parameter int CONV_CYC = 280,
  parameter int LEAD_CYC = 3,
  parameter int SCK_HI   = 5,
  parameter int SCK_LO   = 5,
  parameter int PERIOD   = 400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic             adc_conv,
  output logic             adc_sck,
  input  logic             adc_sdo,
  output logic             o_valid,
  input  logic             o_ready,
  output logic [WIDTH-1:0] o_data
);

  logic             start_ok;
  logic             cap;
  logic             cap_last;
  logic             done;
  logic [WIDTH-1:0] word;

  assign start_ok = run && (!o_valid || o_ready);

  adc_reader_seq #(
    .WIDTH(WIDTH), .CONV_CYC(CONV_CYC), .LEAD_CYC(LEAD_CYC),
    .SCK_HI(SCK_HI), .SCK_LO(SCK_LO), .PERIOD(PERIOD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok),
    .conv(adc_conv), .sck(adc_sck), .cap(cap), .cap_last(cap_last)
  );

  adc_reader_shift #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst_n(rst_n), .sdo(adc_sdo), .cap(cap),
    .cap_last(cap_last), .word(word), .done(done)
  );

  adc_reader_slot #(.WIDTH(WIDTH)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(done), .din(word),
    .ready(o_ready), .valid(o_valid), .data(o_data)
  );

endmodule

// File: rtl/adc_reader_chk.sv
`timescale 1ns/1ps
module adc_reader_chk #(
  parameter int WIDTH     = 12,
  parameter int CONV_CYC  = 280,
  parameter int QUIET_CYC = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             adc_conv,
  input logic             adc_sck,
  input logic             o_valid,
  input logic             o_ready,
  input logic [WIDTH-1:0] o_data
);

  localparam int HI_W = $clog2(CONV_CYC + 2);
  localparam int FC_W = $clog2(WIDTH + 1);
  localparam int Q_W  = $clog2(QUIET_CYC + 2);

  logic [HI_W-1:0] hi_cnt;
  logic [FC_W-1:0] fall_cnt;
  logic [Q_W-1:0]  q_cnt;
  logic            conv_d, sck_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      fall_cnt <= '0;
      q_cnt    <= Q_W'(QUIET_CYC);
      conv_d   <= 1'b0;
      sck_d    <= 1'b0;
    end else begin
      conv_d <= adc_conv;
      sck_d  <= adc_sck;
      if (!adc_conv) hi_cnt <= '0;
      else if (hi_cnt != {HI_W{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
      if (adc_conv && !conv_d) fall_cnt <= '0;
      else if (sck_d && !adc_sck) fall_cnt <= fall_cnt + 1'b1;
      if (sck_d && !adc_sck) q_cnt <= Q_W'(1);
      else if (q_cnt != {Q_W{1'b1}}) q_cnt <= q_cnt + 1'b1;
    end
  end

  assert_conv_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_conv) |-> hi_cnt == HI_W'(CONV_CYC));

  assert_sck_static_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> !adc_sck);

  assert_fall_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sck) |-> fall_cnt < FC_W'(WIDTH - 1));

  assert_falls_per_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_valid) |-> fall_cnt == FC_W'(WIDTH - 1));

  assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data)));

  assert_no_start_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> !$rose(adc_conv));

  assert_start_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv) |-> $past(run));

  assert_quiet_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv) |-> q_cnt >= Q_W'(QUIET_CYC));

endmodule

bind adc_reader adc_reader_chk #(.WIDTH(WIDTH), .CONV_CYC(CONV_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .adc_conv(adc_conv),
  .adc_sck(adc_sck), .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data)
);

// File: tb/tb_adc_reader.sv
`timescale 1ns/1ps
module tb_adc_reader;

  localparam int WIDTH = 12;
  localparam int NVEC  = 8;
  localparam int LAT   = 280 + 3 + 11 * (5 + 5) + 1;
  localparam logic [WIDTH-1:0] VEC [NVEC] = '{
    12'h000, 12'hFFF, 12'hA5A, 12'h5A5, 12'h800, 12'h001, 12'h7FE, 12'h3C9
  };

  logic clk = 1'b0;
  logic rst_n, run, adc_sdo, o_ready;
  logic adc_conv, adc_sck, o_valid;
  logic [WIDTH-1:0] o_data;

  always #2.5 clk = ~clk;

  adc_reader dut (
    .clk(clk), .rst_n(rst_n), .run(run), .adc_conv(adc_conv),
    .adc_sck(adc_sck), .adc_sdo(adc_sdo), .o_valid(o_valid),
    .o_ready(o_ready), .o_data(o_data)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] word_for(input int k);
    if (k < NVEC) return VEC[k];
    return WIDTH'((k * 291) ^ 'hC3A);
  endfunction

  // converter model and pin-timing monitor
  realtime t_rise = 0, t_sck_rise = 0, t_sck_fall = 0;
  int nconv = 0, falls = 0;
  bit steady = 0, have_prev = 0;
  logic [WIDTH-1:0] cur = '0, sh = '0;

  always @(posedge adc_conv) if (rst_n) begin
    if (nconv > 0) begin
      check(falls == 11, "R4 falls per conversion", falls, 11);
      check($realtime - t_sck_fall >= 15.0, "R10 quiet gap ns",
            int'($realtime - t_sck_fall), 15);
    end
    if (steady && have_prev)
      check(int'($realtime - t_rise) == 2000, "R7 period ns", int'($realtime - t_rise), 2000);
    have_prev = 1;
    t_rise = $realtime;
    falls = 0;
    cur = word_for(nconv);
    nconv++;
    adc_sdo = 1'b1;
  end

  always @(negedge adc_conv) if (rst_n) begin
    check(int'($realtime - t_rise) == 1400, "R2 conv width ns", int'($realtime - t_rise), 1400);
    sh = cur;
    #1 adc_sdo = sh[WIDTH-1];
  end

  always @(posedge adc_sck) if (rst_n) begin
    check(!adc_conv, "R3 sck static during conversion", adc_conv, 0);
    if (falls > 0)
      check(int'($realtime - t_sck_fall) == 25, "R4 low phase ns", int'($realtime - t_sck_fall), 25);
    t_sck_rise = $realtime;
  end

  always @(negedge adc_sck) if (rst_n) begin
    falls++;
    check(int'($realtime - t_sck_rise) == 25, "R4 high phase ns", int'($realtime - t_sck_rise), 25);
    t_sck_fall = $realtime;
    if (!adc_conv) begin
      sh = {sh[WIDTH-2:0], 1'b0};
      #1 adc_sdo = sh[WIDTH-1];
    end
  end

  always @(posedge o_valid) if (rst_n)
    check(int'($realtime - t_rise) == LAT * 5, "R6 latency ns", int'($realtime - t_rise), LAT * 5);

  task automatic wait_valid(input string tag);
    int n = 0;
    while (!o_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!o_valid) check(0, tag, 0, 1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [WIDTH-1:0] held;
    int n0, bad;
    rst_n = 1'b0; run = 1'b0; o_ready = 1'b1; adc_sdo = 1'b0;
    repeat (5) @(negedge clk);
    check(adc_conv == 1'b0, "R1 reset conv", adc_conv, 0);
    check(adc_sck == 1'b0, "R1 reset sck", adc_sck, 0);
    check(o_valid == 1'b0, "R1 reset valid", o_valid, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(nconv == 0, "R9 no start while run low", nconv, 0);

    // table walk: streaming with consumer always ready
    steady = 1;
    run = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      wait_valid("R6 valid timeout");
      check(o_data == VEC[i], "R5 word bits", int'(o_data), int'(VEC[i]));
      @(negedge clk);
      check(!o_valid, "R8 one-cycle valid when ready", o_valid, 0);
    end

    // back-pressure
    o_ready = 1'b0;
    steady = 0;
    wait_valid("R8 valid timeout");
    held = o_data;
    check(o_data == word_for(8), "R8 held word", int'(o_data), int'(word_for(8)));
    n0 = nconv;
    bad = 0;
    repeat (700) begin
      @(negedge clk);
      if (!o_valid || o_data != held) bad++;
    end
    check(bad == 0, "R8 word held under back-pressure", bad, 0);
    check(nconv == n0, "R8 no conversion while held", nconv, n0);
    o_ready = 1'b1;
    @(negedge clk);
    check(!o_valid, "R8 accept clears valid", o_valid, 0);
    wait_valid("R8 resume timeout");
    check(o_data == word_for(9), "R8 next word after release", int'(o_data), int'(word_for(9)));
    @(negedge clk);

    // run dropped mid-conversion
    @(posedge adc_conv);
    @(negedge clk);
    run = 1'b0;
    wait_valid("R9 finish timeout");
    check(o_data == word_for(10), "R9 in-flight word delivered", int'(o_data), int'(word_for(10)));
    @(negedge clk);
    n0 = nconv;
    repeat (900) @(negedge clk);
    check(nconv == n0, "R9 no start after run low", nconv, n0);
    check(!o_valid && !adc_conv && !adc_sck, "R9 idle pins", int'({o_valid, adc_conv, adc_sck}), 0);

    finish_run();
  end

endmodule